// File: doc/BRIEF.md
# Status Channel Calendar Sequencer

This block generates the receive-side flow-control status stream of a packet interface that reports per-port fill state over a narrow 2-bit status channel. A calendar of up to 128 port numbers is held in 32 parity-protected words. Software loads and reads these words through a small register port while the interface is disabled. Once the interface and the status channel are both enabled, the block runs through the calendar over and over. For each slot it emits one 2-bit code, which it derives from the fill hint of the port named in that slot.

Each status sequence opens with a framing code. The calendar slots follow, with the first `seq_len` slots repeated `rep_cnt` times. A 2-bit diagonal-free parity code closes the sequence, and the next sequence starts on the following cycle. A per-port mask forces the starving code so that a port can never assert backpressure. A calendar word with broken parity, or an entry that names a port outside the configured range, raises a sticky error flag and is reported as satisfied.

Top module: `stat_cal_seq`

## Requirements
- R1: After reset, and whenever `if_en` or `st_en` is sampled low, `stat_o` is 2'b11 (the framing code) from the next clock edge onward.
- R2: While `if_en` is low, `cfg_wr` stores the 17-bit `cfg_wdata` in word `cfg_addr`. `cfg_rd` returns that word on `cfg_rdata` one cycle later, and `cfg_rdata` is zero in any cycle after no read. Word k holds calendar entries 4k..4k+3: entry 4k is in bits 3:0, entry 4k+1 in bits 7:4, and so on. Bit 16 is the parity bit.
- R3: While `if_en` is high, writes are ignored and reads return zero, and the running status stream is not disturbed.
- R4: A sequence is the framing code 2'b11, then `seq_len`×`rep_cnt` slot codes, then the parity code, after which the next sequence starts at once. With both enables sampled high at edge E0, the framing code occupies the cycle after E0 and the first slot code appears after the following edge.
- R5: Within each repetition, slot j (j = 0..seq_len-1) uses calendar entry j. A `seq_len` of 0 means 128 slots, and a `rep_cnt` of 0 means 256 repetitions.
- R6: A slot code is the 2-bit fill hint of the named port p, taken from `fill_hint[2p+1:2p]`, where 00 means starving, 01 hungry and 10 satisfied. A hint of 11 is reported as 10.
- R7: If `ign_mask[p]` is set, every slot naming port p reports 00 (starving), whatever its hint.
- R8: A slot reports 10 and sets `cal_err` when its word fails odd parity (the XOR of all 17 bits is not 1) or when its entry exceeds `port_cnt_m1`. This check takes priority over the mask. `cal_err` stays set until reset.
- R9: In the parity code, bit 1 is the inverted XOR of bit 1 of every slot code in the sequence. Bit 0 is the inverted XOR of bit 0 of every slot code.
- R10: A slot code is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable; locks the calendar port when high |
| st_en | input | 1 | Status channel enable |
| port_cnt_m1 | input | 4 | Number of ports minus one |
| seq_len | input | 7 | Calendar slots per repetition (0 = 128) |
| rep_cnt | input | 8 | Repetitions per sequence (0 = 256) |
| ign_mask | input | 16 | Per-port force-starving mask |
| fill_hint | input | 32 | 2-bit fill hint per port, port p at bits 2p+1:2p |
| cfg_wr | input | 1 | Calendar word write strobe |
| cfg_rd | input | 1 | Calendar word read strobe |
| cfg_addr | input | 5 | Calendar word index |
| cfg_wdata | input | 17 | Calendar word to write (parity in bit 16) |
| cfg_rdata | output | 17 | Calendar word read back, one cycle after `cfg_rd` |
| stat_o | output | 2 | Status channel code |
| cal_err | output | 1 | Sticky calendar error flag |

## Verification
Several properties are checked on every cycle: the framing code is held whenever the channel is not running, reads return zero while the interface is locked, the error flag is sticky, the flag rises only out of a running cycle, and the slot encoder never produces the framing code. Other behaviour can only be shown by the bench scenarios, because each depends on a whole stream compared against a model. These cover the exact slot order, the LEN×M repetition structure including a length field of zero, the hint-to-code mapping, the effect of the mask, the inverted column parity, and an unchanged stream and calendar after an attempted write during operation.

// File: rtl/stat_cal_pkg.sv
package stat_cal_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SLOT = 2'd1,
        PH_DIP  = 2'd2
    } phase_e;

    localparam logic [1:0] ST_STARVE = 2'b00;
    localparam logic [1:0] ST_HUNGRY = 2'b01;
    localparam logic [1:0] ST_SATIS  = 2'b10;
    localparam logic [1:0] ST_FRAME  = 2'b11;

endpackage

// File: rtl/cal_store.sv
module cal_store #(
    parameter int N_WORDS = 32,
    parameter int WORD_W  = 17,
    localparam int ADDR_W = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [WORD_W-1:0] look_word
);

    logic [WORD_W-1:0] mem_q [N_WORDS];
    logic [WORD_W-1:0] rdata_d, rdata_q;

    // Read data is zero in any cycle that follows no read.
    always_comb begin
        rdata_d = rd_en ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata     = rdata_q;
    assign look_word = mem_q[look_addr];

endmodule

// File: rtl/slot_encode.sv
module slot_encode import stat_cal_pkg::*; #(
    parameter int PORT_W       = 4,
    parameter int ENT_PER_WORD = 4,
    localparam int N_PORTS     = 1 << PORT_W,
    localparam int SEL_W       = $clog2(ENT_PER_WORD),
    localparam int WORD_W      = PORT_W * ENT_PER_WORD + 1
) (
    input  logic [WORD_W-1:0]    word,
    input  logic [SEL_W-1:0]     sel,
    input  logic [PORT_W-1:0]    port_max,
    input  logic [N_PORTS-1:0]   ign_mask,
    input  logic [2*N_PORTS-1:0] fill_hint,
    output logic [1:0]           code,
    output logic                 err
);

    logic [PORT_W-1:0] port;
    logic [1:0]        hint;
    logic              par_bad;
    logic              range_bad;

    always_comb begin
        port      = word[int'(sel)*PORT_W +: PORT_W];
        hint      = fill_hint[int'(port)*2 +: 2];
        par_bad   = ~(^word);
        range_bad = port > port_max;
        err       = par_bad | range_bad;
        if (err) begin
            code = ST_SATIS;
        end else if (ign_mask[port]) begin
            code = ST_STARVE;
        end else if (hint == ST_FRAME) begin
            code = ST_SATIS;
        end else begin
            code = hint;
        end
    end

endmodule

// File: rtl/stat_cal_seq.sv
module stat_cal_seq import stat_cal_pkg::*; #(
    parameter int N_WORDS      = 32,
    parameter int ENT_PER_WORD = 4,
    parameter int PORT_W       = 4,
    parameter int M_W          = 8,
    localparam int ADDR_W      = $clog2(N_WORDS),
    localparam int N_ENT       = N_WORDS * ENT_PER_WORD,
    localparam int LEN_W       = $clog2(N_ENT),
    localparam int SEL_W       = $clog2(ENT_PER_WORD),
    localparam int N_PORTS     = 1 << PORT_W,
    localparam int WORD_W      = PORT_W * ENT_PER_WORD + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 if_en,
    input  logic                 st_en,
    input  logic [PORT_W-1:0]    port_cnt_m1,
    input  logic [LEN_W-1:0]     seq_len,
    input  logic [M_W-1:0]       rep_cnt,
    input  logic [N_PORTS-1:0]   ign_mask,
    input  logic [2*N_PORTS-1:0] fill_hint,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    output logic [1:0]           stat_o,
    output logic                 cal_err
);

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] slot;
        logic [M_W-1:0]   rep;
        logic [1:0]       dip;
        logic [1:0]       stat;
        logic             err;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_SYNC, slot: '0, rep: '0,
                                 dip: '0, stat: ST_FRAME, err: 1'b0};

    seq_t              seq_d, seq_q;
    logic              running;
    logic [WORD_W-1:0] cur_word;
    logic [1:0]        slot_code;
    logic              slot_err;

    assign running = if_en & st_en;

    cal_store #(
        .N_WORDS (N_WORDS),
        .WORD_W  (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr & ~if_en),
        .rd_en     (cfg_rd & ~if_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .look_addr (seq_q.slot[LEN_W-1:SEL_W]),
        .look_word (cur_word)
    );

    slot_encode #(
        .PORT_W       (PORT_W),
        .ENT_PER_WORD (ENT_PER_WORD)
    ) u_enc (
        .word      (cur_word),
        .sel       (seq_q.slot[SEL_W-1:0]),
        .port_max  (port_cnt_m1),
        .ign_mask  (ign_mask),
        .fill_hint (fill_hint),
        .code      (slot_code),
        .err       (slot_err)
    );

    always_comb begin
        seq_d = seq_q;
        if (!running) begin
            seq_d.phase = PH_SYNC;
            seq_d.slot  = '0;
            seq_d.rep   = '0;
            seq_d.dip   = '0;
            seq_d.stat  = ST_FRAME;
        end else begin
            unique case (seq_q.phase)
                PH_SYNC: begin
                    seq_d.stat  = ST_FRAME;
                    seq_d.phase = PH_SLOT;
                    seq_d.slot  = '0;
                    seq_d.rep   = '0;
                    seq_d.dip   = '0;
                end
                PH_SLOT: begin
                    seq_d.stat = slot_code;
                    seq_d.dip  = seq_q.dip ^ slot_code;
                    seq_d.err  = seq_q.err | slot_err;
                    if (seq_q.slot == seq_len - LEN_W'(1)) begin
                        seq_d.slot = '0;
                        if (seq_q.rep == rep_cnt - M_W'(1)) begin
                            seq_d.rep   = '0;
                            seq_d.phase = PH_DIP;
                        end else begin
                            seq_d.rep = seq_q.rep + M_W'(1);
                        end
                    end else begin
                        seq_d.slot = seq_q.slot + LEN_W'(1);
                    end
                end
                PH_DIP: begin
                    seq_d.stat  = ~seq_q.dip;
                    seq_d.phase = PH_SYNC;
                end
                default: begin
                    seq_d.phase = PH_SYNC;
                    seq_d.stat  = ST_FRAME;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stat_o  = seq_q.stat;
    assign cal_err = seq_q.err;

endmodule

// File: rtl/stat_cal_seq_chk.sv
module stat_cal_seq_chk #(
    parameter int WORD_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              if_en,
    input logic              st_en,
    input logic [1:0]        stat_o,
    input logic [1:0]        slot_code,
    input logic              cal_err,
    input logic [WORD_W-1:0] cfg_rdata
);

    AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(if_en && st_en) |=> stat_o == 2'b11); // R1

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        if_en |=> cfg_rdata == '0); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |=> cal_err); // R8

    AST_ERR_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) |-> $past(if_en && st_en)); // R8

    AST_SLOT_NOT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        slot_code != 2'b11); // R10

endmodule

bind stat_cal_seq stat_cal_seq_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_en     (if_en),
    .st_en     (st_en),
    .stat_o    (stat_o),
    .slot_code (slot_code),
    .cal_err   (cal_err),
    .cfg_rdata (cfg_rdata)
);

// File: tb/tb_stat_cal_seq.sv
module tb_stat_cal_seq;

    typedef struct packed {
        logic [6:0]  len;
        logic [7:0]  m;
        logic [3:0]  pcnt;
        logic [15:0] ign;
        logic [5:0]  bad;      // word with broken parity, 63 = none
        logic        exp_err;
        logic        lock;     // exercise the locked register port
    } scen_t;

    localparam int NSCN = 6;
    localparam scen_t SCN [NSCN] = '{
        '{len: 7'd4,  m: 8'd1, pcnt: 4'd15, ign: 16'h0000, bad: 6'd63, exp_err: 1'b0, lock: 1'b1},
        '{len: 7'd6,  m: 8'd3, pcnt: 4'd15, ign: 16'h00F0, bad: 6'd63, exp_err: 1'b0, lock: 1'b0},
        '{len: 7'd5,  m: 8'd2, pcnt: 4'd7,  ign: 16'h0000, bad: 6'd63, exp_err: 1'b1, lock: 1'b0},
        '{len: 7'd8,  m: 8'd2, pcnt: 4'd15, ign: 16'h4000, bad: 6'd1,  exp_err: 1'b1, lock: 1'b0},
        '{len: 7'd1,  m: 8'd1, pcnt: 4'd15, ign: 16'hFFFF, bad: 6'd63, exp_err: 1'b0, lock: 1'b0},
        '{len: 7'd0,  m: 8'd1, pcnt: 4'd15, ign: 16'h0000, bad: 6'd63, exp_err: 1'b0, lock: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_en = 1'b0;
    logic        st_en = 1'b0;
    logic [3:0]  port_cnt_m1 = '0;
    logic [6:0]  seq_len = '0;
    logic [7:0]  rep_cnt = '0;
    logic [15:0] ign_mask = '0;
    logic [31:0] fill_hint = 32'hB4E1_6C93;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [16:0] cfg_wdata = '0;
    logic [16:0] cfg_rdata;
    logic [1:0]  stat_o;
    logic        cal_err;

    int n_chk = 0;
    int n_err = 0;
    logic [16:0] cal_ref [32];
    scen_t cur;

    always #2.5 clk = ~clk;

    stat_cal_seq dut (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .st_en(st_en),
        .port_cnt_m1(port_cnt_m1), .seq_len(seq_len), .rep_cnt(rep_cnt),
        .ign_mask(ign_mask), .fill_hint(fill_hint),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .stat_o(stat_o), .cal_err(cal_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_slot(input int s);
        logic [16:0] w;
        logic [3:0]  p;
        logic [1:0]  h;
        w = cal_ref[s / 4];
        p = w[(s % 4) * 4 +: 4];
        h = fill_hint[int'(p) * 2 +: 2];
        if ((^w) != 1'b1 || p > cur.pcnt) return 2'b10;
        if (cur.ign[p]) return 2'b00;
        if (h == 2'b11) return 2'b10;
        return h;
    endfunction

    function automatic logic [1:0] exp_stream(input int i, input int l, input int m);
        logic [1:0] acc;
        if (i == 0) return 2'b11;
        if (i <= l * m) return exp_slot((i - 1) % l);
        acc = 2'b00;
        for (int k = 0; k < l * m; k++) acc ^= exp_slot(k % l);
        return ~acc;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; if_en = 1'b0; st_en = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_word(input int a, input logic [16:0] d);
        cfg_addr = a[4:0]; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_word(input int a, output logic [16:0] d);
        cfg_addr = a[4:0]; cfg_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic run_scen(input int si);
        logic [16:0] rb;
        int l, m, per;
        cur = SCN[si];
        do_reset();
        chk("R1 reset stat", 32'(stat_o), 32'h3);
        chk("R8 reset err", 32'(cal_err), 32'h0);
        chk("R2 reset rdata", 32'(cfg_rdata), 32'h0);
        for (int w = 0; w < 32; w++) begin
            logic [15:0] d;
            for (int e = 0; e < 4; e++) d[e*4 +: 4] = 4'(((w * 4 + e) * 7 + si) % 16);
            cal_ref[w] = {~(^d) ^ (w == int'(cur.bad)), d};
            wr_word(w, cal_ref[w]);
        end
        rd_word(0, rb);  chk("R2 readback word0", 32'(rb), 32'(cal_ref[0]));
        rd_word(31, rb); chk("R2 readback word31", 32'(rb), 32'(cal_ref[31]));
        @(negedge clk);
        chk("R2 rdata zero without read", 32'(cfg_rdata), 32'h0);
        seq_len = cur.len; rep_cnt = cur.m; port_cnt_m1 = cur.pcnt; ign_mask = cur.ign;
        if_en = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        chk("R1 status channel off", 32'(stat_o), 32'h3);
        st_en = 1'b1;
        l = (cur.len == 0) ? 128 : int'(cur.len);
        m = (cur.m == 0) ? 256 : int'(cur.m);
        per = l * m + 2;
        for (int k = 0; k < 2 * per; k++) begin
            @(posedge clk); @(negedge clk);
            chk($sformatf("R4 R5 R6 R7 R9 stream idx %0d", k % per), 32'(stat_o),
                32'(exp_stream(k % per, l, m)));
            if (cur.lock && k == 6) chk("R3 locked read zero", 32'(cfg_rdata), 32'h0);
            cfg_wr = cur.lock && (k == 3);
            cfg_rd = cur.lock && (k == 5);
            cfg_addr = '0;
            cfg_wdata = 17'h0_0000;
        end
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        chk("R8 sticky error", 32'(cal_err), 32'(cur.exp_err));
        if (cur.lock) begin
            if_en = 1'b0;
            @(posedge clk); @(negedge clk);
            chk("R1 idle after disable", 32'(stat_o), 32'h3);
            rd_word(0, rb);
            chk("R3 write ignored while enabled", 32'(rb), 32'(cal_ref[0]));
        end else begin
            st_en = 1'b0;
            @(posedge clk); @(negedge clk);
            chk("R1 idle after channel off", 32'(stat_o), 32'h3);
        end
        chk("R8 error held after stop", 32'(cal_err), 32'(cur.exp_err));
    endtask

    initial begin : main
        for (int i = 0; i < NSCN; i++) run_scen(i);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(200_000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule